// File: doc/BRIEF.md
# Hardware Semaphore Pool

This block keeps a fixed pool of hardware semaphores that several requesters share. A requester first takes a lock number from the pool. Any requester can then try to own that lock and later release it. When the number is no longer needed, it goes back to the pool. Taking a number from the pool is kept separate from owning the lock, so a lock number can be handed to a group of requesters before any of them tries to own it.

The block accepts at most one request per cycle. Each request carries an operation code, a lock number and a requester number. Requests from different requesters are assumed to be serialized before they reach the block. One cycle after a request, the block drives a response with a lock number and a one-bit flag. The pool size must be a power of two.

Top module: `lock_pool`

## Requirements
- R1: After reset, every lock is in the pool and not held, and `rsp_valid` is 0.
- R2: An allocate request (`req_op` = 0) with at least one free lock marks the lowest-numbered free lock as allocated and not held. It responds with that number and flag 0.
- R3: An allocate request when every lock is allocated responds with flag 1 and changes no lock.
- R4: A return request (`req_op` = 1) on an allocated lock puts that lock back in the pool, so a later allocate can hand it out again. It responds with flag 0.
- R5: A try request (`req_op` = 2) on an allocated lock that nobody holds makes the requester the owner and responds with flag 1.
- R6: A try request on a lock held by another requester responds with flag 0 and leaves the owner unchanged.
- R7: A try request by the current owner responds with flag 1, and the lock stays held by that owner.
- R8: A try request on a lock that is not allocated responds with flag 0 and leaves the lock unheld.
- R9: A release request (`req_op` = 3) from the owner clears the held state and responds with flag 1, meaning the lock was held.
- R10: A release request from a requester that is not the owner changes nothing. It still responds with flag 1, because the lock is held.
- R11: A release request on a lock that nobody holds responds with flag 0.
- R12: Returning a lock also clears its held state and its owner. After the lock is allocated again, any requester can take it.
- R13: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1. For return, try and release, `rsp_id` echoes `req_lock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 0 allocate, 1 return, 2 try, 3 release |
| req_lock | input | log2(NLOCK) | Lock number (unused for allocate) |
| req_who | input | WHO_W | Number of the requester |
| rsp_valid | output | 1 | A response is present |
| rsp_id | output | log2(NLOCK) | Allocated or addressed lock number |
| rsp_flag | output | 1 | Status flag of the operation |

## Verification
The bench builds the block with a pool of four locks and four requesters (NLOCK = 4, WHO_W = 2). With four locks, exhausting the pool takes only a few requests, so the full-pool refusal, the refill through return, and the lowest-number choice after holes appear in the pool can all be exercised. With four requester numbers, the bench can test ownership contention: a try by a second requester, a release by a non-owner, and a lock that is returned while someone still holds it.

// File: rtl/lkp_pkg.sv
package lkp_pkg;

  typedef enum logic [1:0] {
    OP_ALLOC   = 2'd0,
    OP_RETURN  = 2'd1,
    OP_TRY     = 2'd2,
    OP_RELEASE = 2'd3
  } lk_op_t;

  // Status flag of a response, from the decoded pool state.
  function automatic logic resp_flag(lk_op_t op, logic any_free, logic try_ok,
                                     logic was_held);
    case (op)
      OP_ALLOC:   resp_flag = !any_free;
      OP_RETURN:  resp_flag = 1'b0;
      OP_TRY:     resp_flag = try_ok;
      default:    resp_flag = was_held;
    endcase
  endfunction

  // A try is granted when the lock is allocated and either free or already ours.
  function automatic logic try_granted(logic allocated, logic held, logic same_owner);
    try_granted = allocated && (!held || same_owner);
  endfunction

endpackage

// File: rtl/lk_first_free.sv
module lk_first_free #(
  parameter int N    = 16,
  parameter int ID_W = $clog2(N)
) (
  input  logic [N-1:0]    free_vec,
  output logic            found,
  output logic [ID_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        found = 1'b1;
        idx   = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/lk_slot.sv
module lk_slot #(
  parameter int WHO_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_alloc,
  input  logic             set_free,
  input  logic             set_held,
  input  logic             clr_held,
  input  logic [WHO_W-1:0] who,
  output logic             allocated,
  output logic             held,
  output logic [WHO_W-1:0] owner
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allocated <= 1'b0;
      held      <= 1'b0;
      owner     <= '0;
    end else if (set_alloc) begin
      allocated <= 1'b1;
      held      <= 1'b0;
      owner     <= '0;
    end else if (set_free) begin
      allocated <= 1'b0;
      held      <= 1'b0;
      owner     <= '0;
    end else if (set_held) begin
      held      <= 1'b1;
      owner     <= who;
    end else if (clr_held) begin
      held      <= 1'b0;
      owner     <= '0;
    end
  end
endmodule

// File: rtl/lock_pool.sv
module lock_pool
  import lkp_pkg::*;
#(
  parameter  int NLOCK = 16,
  parameter  int WHO_W = 4,
  localparam int ID_W  = $clog2(NLOCK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [ID_W-1:0]  req_lock,
  input  logic [WHO_W-1:0] req_who,
  output logic             rsp_valid,
  output logic [ID_W-1:0]  rsp_id,
  output logic             rsp_flag
);
  lk_op_t           op;
  logic [NLOCK-1:0] alloc_vec;
  logic [NLOCK-1:0] held_vec;
  logic [WHO_W-1:0] owner_arr [NLOCK];

  logic             any_free;
  logic [ID_W-1:0]  free_idx;
  logic             sel_alloc, sel_held, owner_match, try_ok;

  // Named events, also watched by the checker.
  logic evt_grant, evt_full, evt_ret, evt_acq, evt_rel, evt_rel_denied, evt_try_fail;

  assign op          = lk_op_t'(req_op);
  assign sel_alloc   = alloc_vec[req_lock];
  assign sel_held    = held_vec[req_lock];
  assign owner_match = (owner_arr[req_lock] == req_who);
  assign try_ok      = try_granted(sel_alloc, sel_held, owner_match);

  lk_first_free #(.N(NLOCK), .ID_W(ID_W)) u_pick (
    .free_vec (~alloc_vec),
    .found    (any_free),
    .idx      (free_idx)
  );

  assign evt_grant      = req_valid && (op == OP_ALLOC)   && any_free;
  assign evt_full       = req_valid && (op == OP_ALLOC)   && !any_free;
  assign evt_ret        = req_valid && (op == OP_RETURN)  && sel_alloc;
  assign evt_acq        = req_valid && (op == OP_TRY)     && sel_alloc && !sel_held;
  assign evt_try_fail   = req_valid && (op == OP_TRY)     && !try_ok;
  assign evt_rel        = req_valid && (op == OP_RELEASE) && sel_held && owner_match;
  assign evt_rel_denied = req_valid && (op == OP_RELEASE) && sel_held && !owner_match;

  for (genvar g = 0; g < NLOCK; g++) begin : g_slot
    logic hit;
    assign hit = (req_lock == ID_W'(g));
    lk_slot #(.WHO_W(WHO_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_alloc (evt_grant && (free_idx == ID_W'(g))),
      .set_free  (evt_ret && hit),
      .set_held  (evt_acq && hit),
      .clr_held  (evt_rel && hit),
      .who       (req_who),
      .allocated (alloc_vec[g]),
      .held      (held_vec[g]),
      .owner     (owner_arr[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_flag  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_flag <= resp_flag(op, any_free, try_ok, sel_held);
        rsp_id   <= (op == OP_ALLOC) ? (any_free ? free_idx : '0) : req_lock;
      end
    end
  end
endmodule

// File: rtl/lock_pool_chk.sv
module lock_pool_chk #(
  parameter int NLOCK = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             rsp_flag,
  input logic [NLOCK-1:0] alloc_vec,
  input logic [NLOCK-1:0] held_vec,
  input logic             evt_grant,
  input logic             evt_full,
  input logic             evt_rel_denied,
  input logic             evt_try_fail
);
  // R13
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R13
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R2
  grant_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_grant |=> !rsp_flag && ($countones(alloc_vec) == $countones($past(alloc_vec)) + 1));
  // R3
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_full |=> rsp_flag && $stable(alloc_vec) && $stable(held_vec));
  // R10
  foreign_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rel_denied |=> rsp_flag && $stable(held_vec));
  // R6
  try_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_try_fail |=> !rsp_flag && $stable(held_vec));
  // R12
  held_in_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_vec & ~alloc_vec) == '0);
endmodule

bind lock_pool lock_pool_chk #(.NLOCK(NLOCK)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .rsp_valid      (rsp_valid),
  .rsp_flag       (rsp_flag),
  .alloc_vec      (alloc_vec),
  .held_vec       (held_vec),
  .evt_grant      (evt_grant),
  .evt_full       (evt_full),
  .evt_rel_denied (evt_rel_denied),
  .evt_try_fail   (evt_try_fail)
);

// File: tb/test_lock_pool.sv
module test_lock_pool;
  localparam int NL   = 4;
  localparam int WW   = 2;
  localparam int IW   = $clog2(NL);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = '0;
  logic [IW-1:0] req_lock = '0;
  logic [WW-1:0] req_who = '0;
  logic          rsp_valid;
  logic [IW-1:0] rsp_id;
  logic          rsp_flag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lock_pool #(.NLOCK(NL), .WHO_W(WW)) i_lock_pool (
    .clk, .rst_n, .req_valid, .req_op, .req_lock, .req_who,
    .rsp_valid, .rsp_id, .rsp_flag
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Issue one request on a falling edge, sample the response one cycle later.
  task automatic issue(input int op, input int lk, input int who,
                       output int id, output int flag);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = 2'(op);
    req_lock  = IW'(lk);
    req_who   = WW'(who);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R13 rsp_valid", int'(rsp_valid), 1);
    id   = int'(rsp_id);
    flag = int'(rsp_flag);
  endtask

  task automatic t_reset();
    chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
  endtask

  task automatic t_alloc_fill();
    int id, fl;
    for (int i = 0; i < NL; i++) begin
      issue(0, 0, 0, id, fl);
      chk("R2 alloc id", id, i);
      chk("R2 alloc flag", fl, 0);
    end
    issue(0, 0, 0, id, fl);
    chk("R3 full flag", fl, 1);
    @(negedge clk);
    chk("R13 idle no rsp", int'(rsp_valid), 0);
  endtask

  task automatic t_return_refill();
    int id, fl;
    issue(1, 2, 0, id, fl);
    chk("R4 return flag", fl, 0);
    chk("R13 return echo", id, 2);
    issue(0, 0, 0, id, fl);
    chk("R4 realloc id", id, 2);
    issue(1, 1, 0, id, fl);
    issue(1, 0, 0, id, fl);
    issue(0, 0, 0, id, fl);
    chk("R2 lowest after holes", id, 0);
    issue(0, 0, 0, id, fl);
    chk("R2 next lowest", id, 1);
    issue(0, 0, 0, id, fl);
    chk("R3 full again", fl, 1);
  endtask

  task automatic t_ownership();
    int id, fl;
    issue(2, 1, 1, id, fl);
    chk("R5 try free", fl, 1);
    issue(2, 1, 2, id, fl);
    chk("R6 try contended", fl, 0);
    issue(2, 1, 1, id, fl);
    chk("R7 try by owner", fl, 1);
    issue(3, 1, 2, id, fl);
    chk("R10 foreign release flag", fl, 1);
    issue(2, 1, 2, id, fl);
    chk("R10 still held after foreign release", fl, 0);
    issue(3, 1, 1, id, fl);
    chk("R9 owner release flag", fl, 1);
    chk("R13 release echo", id, 1);
    issue(3, 1, 1, id, fl);
    chk("R11 release unheld", fl, 0);
    issue(2, 1, 2, id, fl);
    chk("R6 owner unchanged then free", fl, 1);
  endtask

  task automatic t_unallocated();
    int id, fl;
    issue(1, 3, 0, id, fl);
    issue(2, 3, 0, id, fl);
    chk("R8 try unallocated", fl, 0);
    chk("R13 try echo", id, 3);
    issue(3, 3, 0, id, fl);
    chk("R8 unallocated stays unheld", fl, 0);
  endtask

  task automatic t_return_clears();
    int id, fl;
    issue(1, 1, 0, id, fl);
    issue(0, 0, 0, id, fl);
    chk("R12 realloc lowest", id, 1);
    issue(2, 1, 0, id, fl);
    chk("R12 new requester takes lock", fl, 1);
    issue(3, 1, 2, id, fl);
    chk("R12 old owner cannot release", fl, 1);
    issue(2, 1, 2, id, fl);
    chk("R12 old owner cannot take", fl, 0);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc_fill();
    t_return_refill();
    t_ownership();
    t_unallocated();
    t_return_clears();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule